// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is the arithmetic/logic unit of an 8-bit accumulator machine whose only status flag is carry. On each strobe it takes the accumulator, a second operand byte that has already been selected, the incoming carry and an operation code. It returns the new accumulator, the new carry and, for operations that write elsewhere, a byte result or a 16-bit result tagged with its destination.

The 16-bit side does three jobs. It adds a register pair to the HL pair. It increments or decrements a pair. It adds the operand byte, read as a signed offset, to the stack pointer, with the sum written to either SP or HL.

Each operation has its own carry rule. Compare touches only carry, AND clears it, and increments and decrements leave it alone. All results are registered, so they appear one clock after the strobe and hold until the next strobe.

Top module: `acc_alu`

## Requirements
- R1: After synchronous reset all outputs are zero: `vld_o`, `acc_o`, `cy_o`, `byte_o`, `word_o` and `dst_o` (0 = no destination).
- R2: `vld_o` is high for exactly the cycle after each cycle with `vld_i` high. When `vld_i` is low, every output other than `vld_o` keeps its value. On a strobe, any operation that makes no byte result drives `byte_o` to 0, and any operation that makes no 16-bit result drives `word_o` to 0 and `dst_o` to 0.
- R3: Op 1 (add) sets A to (A+operand) mod 256. Op 2 (add with carry) sets A to (A+operand+carry) mod 256. Both set carry exactly when the true sum is above 0xFF. Op 1 ignores the incoming carry.
- R4: Op 3 (subtract) sets A to (A-operand) mod 256. Op 4 (subtract with borrow) sets A to (A-operand-carry) mod 256. Both set carry exactly when the true difference is negative.
- R5: Op 5 writes A AND operand to A and forces carry to 0.
- R6: Op 6 (compare) leaves A unchanged and sets carry exactly when A is below the operand, both read as unsigned.
- R7: Op 7 sets A to A XOR 0xFF and keeps carry. Op 8 inverts carry. Op 9 sets carry to 1. Ops 8 and 9 leave A unchanged.
- R8: Op 10 drives `byte_o` to (operand+1) mod 256, and op 11 drives it to (operand-1) mod 256. Neither changes A or carry.
- R9: Op 12 drives `word_o` to (HL+pair) mod 65536 and `dst_o` to 1 (HL). Carry is set exactly when the true sum exceeds 0xFFFF.
- R10: Op 13 drives `word_o` to (pair+1) mod 65536, and op 14 drives it to (pair-1) mod 65536. Both drive `dst_o` to 3 (pair) and leave carry unchanged.
- R11: Ops 15 and 16 add the operand, read as a two's-complement value from -128 to 127, to SP. `word_o` is the sum mod 65536, and carry is set exactly when the true sum is below 0 or above 0xFFFF. `dst_o` is 2 (SP) for op 15 and 1 (HL) for op 16.
- R12: Op 0 and ops 17 to 31 pass A and carry through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operation strobe |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand byte (also the signed SP offset) |
| cy_i | input | 1 | Current carry |
| hl_i | input | 16 | Current HL pair |
| sp_i | input | 16 | Current stack pointer |
| pair_i | input | 16 | Pair operand for the HL add and for 16-bit increment/decrement |
| vld_o | output | 1 | Result valid, one cycle after the strobe |
| acc_o | output | 8 | New accumulator |
| cy_o | output | 1 | New carry |
| byte_o | output | 8 | Byte increment/decrement result |
| word_o | output | 16 | 16-bit result |
| dst_o | output | 2 | 16-bit destination: 0 none, 1 HL, 2 SP, 3 pair |

## Verification
The bench goes after the carry edges, each on both sides:
- a sum of exactly 0x100 against 0xFF;
- a borrow where the incoming carry alone makes the difference negative;
- compare with equal operands;
- a 16-bit sum that just wraps;
- an SP offset that steps below zero or past 0xFFFF.

A design that kept the carry-out of an 8-bit sum at bit 7 would miss these edges. So would one that read the offset as unsigned, or one that let add-without-carry use the incoming carry. Such a design would report a wrong carry while the 8-bit or 16-bit value still looked right. Increment, decrement, AND and compare are checked for a carry they must not change. Unused codes and idle cycles are checked for outputs that must stay still.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
    parameter int BW = 8;
    parameter int WW = 16;
    localparam int OPW = 5;

    typedef logic [BW-1:0] byte_t;
    typedef logic [WW-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_NOP    = 5'd0,
        OP_ADD    = 5'd1,
        OP_ADC    = 5'd2,
        OP_SUB    = 5'd3,
        OP_SBC    = 5'd4,
        OP_AND    = 5'd5,
        OP_CMP    = 5'd6,
        OP_CPL    = 5'd7,
        OP_CCF    = 5'd8,
        OP_SCF    = 5'd9,
        OP_INC8   = 5'd10,
        OP_DEC8   = 5'd11,
        OP_ADDHL  = 5'd12,
        OP_INC16  = 5'd13,
        OP_DEC16  = 5'd14,
        OP_SPO_SP = 5'd15,
        OP_SPO_HL = 5'd16
    } op_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_HL   = 2'd1,
        DST_SP   = 2'd2,
        DST_PAIR = 2'd3
    } dst_e;

    typedef struct packed {
        byte_t acc;
        logic  cy;
        byte_t aux;
    } res8_t;

    typedef struct packed {
        word_t word;
        dst_e  dst;
        logic  cy;
        logic  hit;
    } res16_t;

    // Sign-extend a byte offset to word width.
    function automatic word_t sext_ofs(input byte_t b);
        return {{(WW-BW){b[BW-1]}}, b};
    endfunction

    // Extended add/sub: bit BW is the carry or borrow.
    function automatic logic [BW:0] ext_arith(input byte_t a, input byte_t b,
                                              input logic c, input logic sub);
        logic [BW:0] r;
        if (sub) r = {1'b0, a} - {1'b0, b} - (BW+1)'(c);
        else     r = {1'b0, a} + {1'b0, b} + (BW+1)'(c);
        return r;
    endfunction
endpackage

// File: rtl/alu8_core.sv
module alu8_core
    import accalu_pkg::*;
(
    input  op_e   op,
    input  byte_t acc,
    input  byte_t opnd,
    input  logic  cy,
    output res8_t res
);
    logic [BW:0] ext;

    always_comb begin
        res = '{acc: acc, cy: cy, aux: '0};
        ext = '0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                ext = ext_arith(acc, opnd, (op == OP_ADC) ? cy : 1'b0, 1'b0);
                res.acc = ext[BW-1:0];
                res.cy  = ext[BW];
            end
            OP_SUB, OP_SBC: begin
                ext = ext_arith(acc, opnd, (op == OP_SBC) ? cy : 1'b0, 1'b1);
                res.acc = ext[BW-1:0];
                res.cy  = ext[BW];
            end
            OP_AND: begin
                res.acc = acc & opnd;
                res.cy  = 1'b0;
            end
            OP_CMP: begin
                ext    = ext_arith(acc, opnd, 1'b0, 1'b1);
                res.cy = ext[BW];
            end
            OP_CPL:  res.acc = ~acc;
            OP_CCF:  res.cy  = ~cy;
            OP_SCF:  res.cy  = 1'b1;
            OP_INC8: res.aux = opnd + byte_t'(1);
            OP_DEC8: res.aux = opnd - byte_t'(1);
            default: ;
        endcase
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import accalu_pkg::*;
(
    input  op_e    op,
    input  byte_t  opnd,
    input  logic   cy,
    input  word_t  hl,
    input  word_t  sp,
    input  word_t  pair,
    output res16_t res
);
    logic [WW:0] ext;
    word_t       ofs;

    always_comb begin
        ofs = sext_ofs(opnd);
        ext = '0;
        res = '{word: '0, dst: DST_NONE, cy: cy, hit: 1'b0};
        unique case (op)
            OP_ADDHL: begin
                ext = {1'b0, hl} + {1'b0, pair};
                res = '{word: ext[WW-1:0], dst: DST_HL, cy: ext[WW], hit: 1'b1};
            end
            OP_INC16: res = '{word: pair + word_t'(1), dst: DST_PAIR, cy: cy, hit: 1'b1};
            OP_DEC16: res = '{word: pair - word_t'(1), dst: DST_PAIR, cy: cy, hit: 1'b1};
            OP_SPO_SP, OP_SPO_HL: begin
                // Signed addend: bit WW of the sum flags leaving 0..max.
                ext = {1'b0, sp} + {ofs[WW-1], ofs};
                res = '{word: ext[WW-1:0],
                        dst: (op == OP_SPO_SP) ? DST_SP : DST_HL,
                        cy: ext[WW], hit: 1'b1};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import accalu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        vld_i,
    input  logic [4:0]  op_i,
    input  logic [7:0]  acc_i,
    input  logic [7:0]  opnd_i,
    input  logic        cy_i,
    input  logic [15:0] hl_i,
    input  logic [15:0] sp_i,
    input  logic [15:0] pair_i,
    output logic        vld_o,
    output logic [7:0]  acc_o,
    output logic        cy_o,
    output logic [7:0]  byte_o,
    output logic [15:0] word_o,
    output logic [1:0]  dst_o
);
    op_e    op;
    res8_t  r8;
    res16_t r16;

    assign op = op_e'(op_i);

    alu8_core u_alu8 (
        .op   (op),
        .acc  (acc_i),
        .opnd (opnd_i),
        .cy   (cy_i),
        .res  (r8)
    );

    alu16_core u_alu16 (
        .op   (op),
        .opnd (opnd_i),
        .cy   (cy_i),
        .hl   (hl_i),
        .sp   (sp_i),
        .pair (pair_i),
        .res  (r16)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            acc_o  <= '0;
            cy_o   <= 1'b0;
            byte_o <= '0;
            word_o <= '0;
            dst_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                acc_o  <= r8.acc;
                cy_o   <= r16.hit ? r16.cy : r8.cy;
                byte_o <= r8.aux;
                word_o <= r16.word;
                dst_o  <= r16.dst;
            end
        end
    end

    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);
    p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> ($stable(acc_o) && $stable(cy_o) && $stable(word_o) && $stable(byte_o)));
    p_and_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i == 5'd5) |=> !cy_o);
    p_cmp_keeps_a_r6: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i == 5'd6) |=> (acc_o == $past(acc_i)));
    p_scf_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i == 5'd9) |=> cy_o);
    p_incdec_cy_r8: assert property (@(posedge clk) disable iff (rst)
        (vld_i && (op_i == 5'd10 || op_i == 5'd11)) |=> (cy_o == $past(cy_i) && acc_o == $past(acc_i)));
    p_pair_cy_r10: assert property (@(posedge clk) disable iff (rst)
        (vld_i && (op_i == 5'd13 || op_i == 5'd14)) |=> (cy_o == $past(cy_i) && dst_o == 2'd3));
    p_unlisted_r12: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i > 5'd16) |=> (acc_o == $past(acc_i) && cy_o == $past(cy_i)));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  opnd_i = '0;
    logic        cy_i = 1'b0;
    logic [15:0] hl_i = '0;
    logic [15:0] sp_i = '0;
    logic [15:0] pair_i = '0;
    logic        vld_o;
    logic [7:0]  acc_o;
    logic        cy_o;
    logic [7:0]  byte_o;
    logic [15:0] word_o;
    logic [1:0]  dst_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int e_vld = 0, e_acc = 0, e_cy = 0, e_byte = 0, e_word = 0, e_dst = 0;
    string prev_tag = "R1";

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst(rst), .vld_i(vld_i), .op_i(op_i), .acc_i(acc_i),
        .opnd_i(opnd_i), .cy_i(cy_i), .hl_i(hl_i), .sp_i(sp_i), .pair_i(pair_i),
        .vld_o(vld_o), .acc_o(acc_o), .cy_o(cy_o), .byte_o(byte_o),
        .word_o(word_o), .dst_o(dst_o)
    );

    task automatic chk(string what, int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic straight from the requirements.
    task automatic model(int op, int a, int b, int c, int hl, int sp, int pr);
        int s;
        int dd;
        e_acc = a; e_cy = c; e_byte = 0; e_word = 0; e_dst = 0;
        case (op)
            1: begin s = a + b;     e_acc = s & 255; e_cy = (s > 255); end
            2: begin s = a + b + c; e_acc = s & 255; e_cy = (s > 255); end
            3: begin s = a - b;     e_acc = s & 255; e_cy = (s < 0); end
            4: begin s = a - b - c; e_acc = s & 255; e_cy = (s < 0); end
            5: begin e_acc = a & b; e_cy = 0; end
            6: e_cy = (a < b);
            7: e_acc = a ^ 255;
            8: e_cy = (c == 0);
            9: e_cy = 1;
            10: e_byte = (b + 1) & 255;
            11: e_byte = (b - 1) & 255;
            12: begin s = hl + pr; e_word = s & 65535; e_cy = (s > 65535); e_dst = 1; end
            13: begin e_word = (pr + 1) & 65535; e_dst = 3; end
            14: begin e_word = (pr - 1) & 65535; e_dst = 3; end
            15, 16: begin
                dd = (b >= 128) ? b - 256 : b;
                s = sp + dd;
                e_word = s & 65535;
                e_cy = (s > 65535 || s < 0);
                e_dst = (op == 15) ? 2 : 1;
            end
            default: ;
        endcase
    endtask

    task automatic step(bit v, int op, int a, int b, int c, int hl, int sp, int pr, string tag);
        @(negedge clk);
        chk("vld_o", int'(vld_o), e_vld, prev_tag);
        chk("acc_o", int'(acc_o), e_acc, prev_tag);
        chk("cy_o", int'(cy_o), e_cy, prev_tag);
        chk("byte_o", int'(byte_o), e_byte, prev_tag);
        chk("word_o", int'(word_o), e_word, prev_tag);
        chk("dst_o", int'(dst_o), e_dst, prev_tag);
        vld_i = v; op_i = 5'(op); acc_i = 8'(a); opnd_i = 8'(b); cy_i = c[0];
        hl_i = 16'(hl); sp_i = 16'(sp); pair_i = 16'(pr);
        e_vld = v;
        if (v) model(op, a, b, c, hl, sp, pr);
        prev_tag = tag;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state is checked by the first step's comparisons
        step(1, 1, 8'hF0, 8'h10, 0, 0, 0, 0, "R3");
        step(1, 1, 8'h12, 8'h34, 1, 0, 0, 0, "R3");
        step(1, 1, 8'hFF, 8'h00, 1, 0, 0, 0, "R3");
        step(1, 2, 8'hFF, 8'h00, 1, 0, 0, 0, "R3");
        step(1, 2, 8'h7F, 8'h80, 0, 0, 0, 0, "R3");
        step(1, 3, 8'h10, 8'h20, 0, 0, 0, 0, "R4");
        step(1, 3, 8'h33, 8'h33, 1, 0, 0, 0, "R4");
        step(1, 4, 8'h00, 8'hFF, 1, 0, 0, 0, "R4");
        step(1, 4, 8'h05, 8'h04, 1, 0, 0, 0, "R4");
        step(1, 4, 8'h05, 8'h05, 1, 0, 0, 0, "R4");
        step(1, 5, 8'hCC, 8'hAA, 1, 0, 0, 0, "R5");
        step(1, 6, 8'h10, 8'h11, 0, 0, 0, 0, "R6");
        step(1, 6, 8'h42, 8'h42, 1, 0, 0, 0, "R6");
        step(1, 6, 8'h90, 8'h01, 1, 0, 0, 0, "R6");
        step(1, 7, 8'h5A, 8'h00, 1, 0, 0, 0, "R7");
        step(1, 8, 8'h11, 8'h00, 0, 0, 0, 0, "R7");
        step(1, 8, 8'h11, 8'h00, 1, 0, 0, 0, "R7");
        step(1, 9, 8'h22, 8'h00, 0, 0, 0, 0, "R7");
        step(1, 10, 8'h01, 8'hFF, 1, 0, 0, 0, "R8");
        step(1, 11, 8'h02, 8'h00, 0, 0, 0, 0, "R8");
        step(1, 12, 8'h03, 8'h00, 0, 16'hFFFF, 0, 16'h0001, "R9");
        step(1, 12, 8'h03, 8'h00, 1, 16'h1234, 0, 16'h1111, "R9");
        step(1, 13, 8'h04, 8'h00, 1, 0, 0, 16'hFFFF, "R10");
        step(1, 14, 8'h04, 8'h00, 0, 0, 0, 16'h0000, "R10");
        step(1, 15, 8'h05, 8'h01, 0, 0, 16'hFFFF, 0, "R11");
        step(1, 15, 8'h05, 8'hFF, 0, 0, 16'h0000, 0, "R11");
        step(1, 15, 8'h05, 8'h80, 0, 0, 16'h0005, 0, "R11");
        step(1, 15, 8'h05, 8'hFF, 1, 0, 16'h0005, 0, "R11");
        step(1, 16, 8'h05, 8'h7F, 1, 0, 16'h1000, 0, "R11");
        step(1, 0, 8'hA5, 8'h5A, 1, 0, 0, 0, "R12");
        step(1, 17, 8'h3C, 8'hFF, 0, 0, 0, 0, "R12");
        step(1, 31, 8'hC3, 8'h01, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R12");
        step(1, 12, 8'h00, 8'h00, 0, 16'h8000, 0, 16'h8000, "R9");
        step(0, 1, 8'hFF, 8'hFF, 1, 1, 1, 1, "R2");
        step(0, 7, 8'h00, 8'h00, 0, 0, 0, 0, "R2");
        step(1, 2, 8'h80, 8'h80, 1, 0, 0, 0, "R3");
        for (int i = 0; i < 400; i++) begin
            bit v = ($urandom_range(0, 3) != 0);
            step(v, int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 65535)), v ? "R12" : "R2");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule